// File: doc/BRIEF.md
# Excitatory–Inhibitory Threshold Operator

This block is a clocked threshold cell in the style of a binary neuron. It adds two unsigned excitatory operands and two unsigned inhibitory operands. It subtracts the inhibitory total from the excitatory total to get a signed net activation. A single register then records whether that activation reaches a threshold word. The intermediate totals, the signed difference and the threshold currently in use are all visible at the ports.

The threshold comes from one of two places. It can be an external word, or it can be an internal down-counting ramp that steps once every two clock cycles and wraps from zero back to its top value. One cell therefore gives different Boolean connectives depending on the threshold it sees. With unit-weight single-bit inputs and no inhibition, a threshold of 1 gives OR and a threshold of 2 gives AND. With a binary-weighted nibble, a threshold of 11 or 13 gives a different sum-of-products function with no change to the wiring. Because the threshold can follow the ramp, the connective can also change over time.

Top module: `thresh_neuron`

## Requirements
- R1: `sum_exc` always equals `exc_a + exc_b` as a 9-bit unsigned value. It is combinational and shows no carry loss.
- R2: `sum_inh` always equals `inh_c + inh_d` as a 9-bit unsigned value. It is combinational.
- R3: `diff` always equals `sum_exc - sum_inh` as a 10-bit two's-complement value. Bit 9 is the sign bit.
- R4: After each rising edge that is not in reset, `fire` is 1 if and only if, just before that edge, the signed `diff` was greater than or equal to `thr_cur` zero-extended to 10 bits. As a result, a negative `diff` never fires.
- R5: `fire` changes only at a rising clock edge. A change on any input between edges does not show on `fire` until the next edge.
- R6: A synchronous active-high `rst` clears `fire` to 0, loads the ramp with 0xFF and clears its step prescaler.
- R7: After reset is released, the ramp drops by one on every second rising edge. After 2·n edges it reads 0xFF−n. It wraps from 0x00 to 0xFF.
- R8: `use_ramp` = 1 makes `thr_cur` the ramp value, and `use_ramp` = 0 makes it `thr_ext`. The choice acts on the very next sampling edge of `fire`.
- R9: With `exc_a`, `exc_b` in {0,1} and both inhibitory inputs at 0, a threshold of 1 gives `fire` = a OR b, and a threshold of 2 gives `fire` = a AND b.
- R10: With `exc_a` = 8·A+4·B+2·C+D (a nibble with bit 3 = A and bit 0 = D) and the other operands at 0, a threshold of 11 gives `fire` = A·(B + C·D). A threshold of 13 gives `fire` = A·B·(C + D).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exc_a | input | 8 | First excitatory operand |
| exc_b | input | 8 | Second excitatory operand |
| inh_c | input | 8 | First inhibitory operand |
| inh_d | input | 8 | Second inhibitory operand |
| thr_ext | input | 8 | External threshold word |
| use_ramp | input | 1 | 1: internal ramp threshold, 0: external |
| sum_exc | output | 9 | Excitatory total |
| sum_inh | output | 9 | Inhibitory total |
| diff | output | 10 | Signed net activation |
| thr_cur | output | 8 | Threshold now applied |
| fire | output | 1 | Registered threshold decision |

## Verification
A wrong adder or subtractor shows on `sum_exc`, `sum_inh` or `diff` in the same cycle. A comparison that treats the difference as unsigned shows one edge later, as a spurious `fire` on a negative activation. A prescaler or ramp that is off by one shows on `thr_cur` within two edges of reset release, as a wrong step value. A bad wrap shows at the 512th edge. A threshold select that is wrong or delayed shows on `thr_cur` at once, and on `fire` at the next edge.

// File: rtl/thn_pkg.sv
package thn_pkg;
    typedef enum logic {
        SRC_EXT  = 1'b0,
        SRC_RAMP = 1'b1
    } thr_src_e;
endpackage

// File: rtl/thn_pair_add.sv
module thn_pair_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    output logic [W:0]   total
);
    always_comb begin
        total = {1'b0, op_x} + {1'b0, op_y};
    end
endmodule

// File: rtl/thn_ramp.sv
module thn_ramp #(
    parameter int W   = 8,
    parameter int DIV = 2
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] level
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  val;
    } ramp_st_t;

    ramp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
            st_d.val = '1;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.val = st_q.val - 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign level = st_q.val;
endmodule

// File: rtl/thn_fire.sv
module thn_fire #(
    parameter int DW = 10,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] net,
    input  logic [TW-1:0] thr,
    output logic          fire
);
    typedef struct packed {
        logic hit;
    } fire_st_t;

    fire_st_t st_d, st_q;
    logic signed [DW-1:0] net_s;
    logic signed [DW-1:0] thr_s;

    always_comb begin
        net_s = $signed(net);
        thr_s = $signed({{(DW-TW){1'b0}}, thr});
        st_d  = st_q;
        if (rst) begin
            st_d.hit = 1'b0;
        end else begin
            st_d.hit = (net_s >= thr_s);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fire = st_q.hit;
endmodule

// File: rtl/thresh_neuron.sv
module thresh_neuron #(
    parameter int OPW      = 8,
    parameter int THW      = 8,
    parameter int RAMP_DIV = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPW-1:0]   exc_a,
    input  logic [OPW-1:0]   exc_b,
    input  logic [OPW-1:0]   inh_c,
    input  logic [OPW-1:0]   inh_d,
    input  logic [THW-1:0]   thr_ext,
    input  logic             use_ramp,
    output logic [OPW:0]     sum_exc,
    output logic [OPW:0]     sum_inh,
    output logic [OPW+1:0]   diff,
    output logic [THW-1:0]   thr_cur,
    output logic             fire
);
    import thn_pkg::*;

    localparam int SUMW = OPW + 1;
    localparam int DIFW = OPW + 2;
    localparam int NGRP = 2;

    logic [OPW-1:0]  grp_x [NGRP];
    logic [OPW-1:0]  grp_y [NGRP];
    logic [SUMW-1:0] grp_s [NGRP];
    logic [THW-1:0]  ramp_val;
    thr_src_e        src;

    assign grp_x[0] = exc_a;
    assign grp_y[0] = exc_b;
    assign grp_x[1] = inh_c;
    assign grp_y[1] = inh_d;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        thn_pair_add #(.W(OPW)) add_i (
            .op_x  (grp_x[g]),
            .op_y  (grp_y[g]),
            .total (grp_s[g])
        );
    end

    assign sum_exc = grp_s[0];
    assign sum_inh = grp_s[1];

    always_comb begin
        diff = {1'b0, grp_s[0]} - {1'b0, grp_s[1]};
    end

    thn_ramp #(.W(THW), .DIV(RAMP_DIV)) ramp_i (
        .clk   (clk),
        .rst   (rst),
        .level (ramp_val)
    );

    always_comb begin
        src     = use_ramp ? SRC_RAMP : SRC_EXT;
        thr_cur = (src == SRC_RAMP) ? ramp_val : thr_ext;
    end

    thn_fire #(.DW(DIFW), .TW(THW)) fire_i (
        .clk  (clk),
        .rst  (rst),
        .net  (diff),
        .thr  (thr_cur),
        .fire (fire)
    );
endmodule

// File: rtl/thresh_neuron_chk.sv
module thresh_neuron_chk #(
    parameter int OPW = 8,
    parameter int THW = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [OPW-1:0] exc_a,
    input logic [OPW-1:0] exc_b,
    input logic [OPW-1:0] inh_c,
    input logic [OPW-1:0] inh_d,
    input logic [THW-1:0] thr_ext,
    input logic           use_ramp,
    input logic [OPW:0]   sum_exc,
    input logic [OPW:0]   sum_inh,
    input logic [OPW+1:0] diff,
    input logic [THW-1:0] thr_cur,
    input logic           fire,
    input logic [THW-1:0] ramp_val
);
    a_r1_sum_exc: assert property (@(posedge clk) disable iff (rst)
        sum_exc == ({1'b0, exc_a} + {1'b0, exc_b}));

    a_r2_sum_inh: assert property (@(posedge clk) disable iff (rst)
        sum_inh == ({1'b0, inh_c} + {1'b0, inh_d}));

    a_r3_diff: assert property (@(posedge clk) disable iff (rst)
        diff == ({1'b0, sum_exc} - {1'b0, sum_inh}));

    a_r4_fire_rule: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (fire == ($signed($past(diff)) >= $signed({2'b00, $past(thr_cur)}))));

    a_r4_neg_quiet: assert property (@(posedge clk) disable iff (rst)
        diff[OPW+1] |=> !fire);

    a_r6_reset: assert property (@(posedge clk)
        rst |=> (!fire && ramp_val == {THW{1'b1}}));

    a_r7_ramp_step: assert property (@(posedge clk) disable iff (rst)
        (ramp_val == $past(ramp_val)) || (ramp_val == $past(ramp_val) - 1'b1));

    a_r8_select: assert property (@(posedge clk) disable iff (rst)
        thr_cur == (use_ramp ? ramp_val : thr_ext));
endmodule

bind thresh_neuron thresh_neuron_chk #(.OPW(OPW), .THW(THW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .exc_a    (exc_a),
    .exc_b    (exc_b),
    .inh_c    (inh_c),
    .inh_d    (inh_d),
    .thr_ext  (thr_ext),
    .use_ramp (use_ramp),
    .sum_exc  (sum_exc),
    .sum_inh  (sum_inh),
    .diff     (diff),
    .thr_cur  (thr_cur),
    .fire     (fire),
    .ramp_val (ramp_val)
);

// File: tb/thresh_neuron_tb_top.sv
module thresh_neuron_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] exc_a = '0, exc_b = '0, inh_c = '0, inh_d = '0, thr_ext = '0;
    logic       use_ramp = 1'b0;
    logic [8:0] sum_exc, sum_inh;
    logic [9:0] diff;
    logic [7:0] thr_cur;
    logic       fire;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    thresh_neuron dut_i (
        .clk(clk), .rst(rst), .exc_a(exc_a), .exc_b(exc_b), .inh_c(inh_c),
        .inh_d(inh_d), .thr_ext(thr_ext), .use_ramp(use_ramp),
        .sum_exc(sum_exc), .sum_inh(sum_inh), .diff(diff),
        .thr_cur(thr_cur), .fire(fire)
    );

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] c;
        logic [7:0] d;
        logic [7:0] t;
        logic       f;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 1'b1},
        '{8'hFF, 8'hFE, 8'hFF, 8'h00, 8'hFF, 1'b0},
        '{8'h8C, 8'h8B, 8'h8C, 8'h8D, 8'hB2, 1'b0},
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
        '{8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0},
        '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b1},
        '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0},
        '{8'h7F, 8'h00, 8'h00, 8'h00, 8'h80, 1'b0},
        '{8'h80, 8'h00, 8'h00, 8'h00, 8'h80, 1'b1},
        '{8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1},
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0},
        '{8'h01, 8'h01, 8'h00, 8'h00, 8'h02, 1'b1},
        '{8'h01, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, b, c, d, t);
        @(negedge clk);
        exc_a = a; exc_b = b; inh_c = c; inh_d = d; thr_ext = t;
    endtask

    task automatic after_edge(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        after_edge(3);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [9:0] exp_d;
        // R6 reset state
        use_ramp = 1'b1;
        after_edge(3);
        chk("R6 fire in reset", {15'd0, fire}, 16'd0);
        chk("R6 ramp load", {8'd0, thr_cur}, 16'h00FF);
        @(negedge clk);
        rst = 1'b0;
        // R7 ramp stepping
        after_edge(1);
        chk("R7 hold after 1 edge", {8'd0, thr_cur}, 16'h00FF);
        after_edge(1);
        chk("R7 step after 2 edges", {8'd0, thr_cur}, 16'h00FE);
        after_edge(2);
        chk("R7 step after 4 edges", {8'd0, thr_cur}, 16'h00FD);
        after_edge(506);
        chk("R7 reaches zero at 510", {8'd0, thr_cur}, 16'h0000);
        after_edge(2);
        chk("R7 wraps at 512", {8'd0, thr_cur}, 16'h00FF);

        // table walk, external threshold (R1..R4, R9)
        use_ramp = 1'b0;
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].a, TBL[i].b, TBL[i].c, TBL[i].d, TBL[i].t);
            #2;
            exp_d = {2'b00, TBL[i].a} + {2'b00, TBL[i].b} - {2'b00, TBL[i].c} - {2'b00, TBL[i].d};
            chk("R1 sum_exc", {7'd0, sum_exc}, {7'd0, {1'b0, TBL[i].a} + {1'b0, TBL[i].b}});
            chk("R2 sum_inh", {7'd0, sum_inh}, {7'd0, {1'b0, TBL[i].c} + {1'b0, TBL[i].d}});
            chk("R3 diff", {6'd0, diff}, {6'd0, exp_d});
            chk("R8 thr_cur ext", {8'd0, thr_cur}, {8'd0, TBL[i].t});
            after_edge(1);
            chk(i >= 9 ? "R9 or/and" : "R4 fire", {15'd0, fire}, {15'd0, TBL[i].f});
        end

        // R10 binary-weighted nibble
        for (int t = 0; t < 2; t++) begin
            for (int nb = 0; nb < 16; nb++) begin
                logic ea, eb, ec, ed, ef;
                ea = nb[3]; eb = nb[2]; ec = nb[1]; ed = nb[0];
                ef = (t == 0) ? (ea & (eb | (ec & ed))) : (ea & eb & (ec | ed));
                apply(8'(nb), 8'd0, 8'd0, 8'd0, (t == 0) ? 8'd11 : 8'd13);
                after_edge(1);
                chk("R10 weighted nibble", {15'd0, fire}, {15'd0, ef});
            end
        end

        // R5 fire holds between edges
        apply(8'h10, 8'h00, 8'h00, 8'h00, 8'h05);
        after_edge(1);
        chk("R5 setup", {15'd0, fire}, 16'd1);
        @(negedge clk);
        inh_c = 8'hFF;
        #2;
        chk("R5 held before edge", {15'd0, fire}, 16'd1);
        after_edge(1);
        chk("R5 updates at edge", {15'd0, fire}, 16'd0);

        // R8 select acts on next edge
        do_reset();
        exc_a = 8'hFE; exc_b = 8'h00; inh_c = 8'h00; inh_d = 8'h00;
        thr_ext = 8'h00; use_ramp = 1'b1;
        after_edge(1);
        chk("R8 ramp threshold blocks", {15'd0, fire}, 16'd0);
        @(negedge clk);
        use_ramp = 1'b0;
        #2;
        chk("R8 thr_cur follows ext", {8'd0, thr_cur}, 16'h0000);
        after_edge(1);
        chk("R8 ext threshold fires", {15'd0, fire}, 16'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule